// File: doc/BRIEF.md
# Colour Palette Lookup Table with Streamed Host Loading

The block holds a table of colours indexed by a pixel code. A host loads it through one narrow byte port: it first writes a starting entry number, then sends the red, green and blue bytes of that entry one after another to a shared data select. An internal phase counter gathers the three bytes, writes the full colour once the blue byte arrives, and moves on to the next entry. A host can therefore load a run of consecutive entries with one index write followed by a stream of data bytes.

On the display side, a pixel code arrives every clock. It is first ANDed with a host-programmable mask, which lets software drop index bits without reloading the table. The masked code then selects an entry, and the entry's colour appears on the output one clock later.

Top module: `pal_lut`

## Requirements
- R1: After reset the mask is all ones, the load cursor is entry 0, the phase is red, every entry holds zero, and `pix_color` is zero.
- R2: A host write uses `host_sel` to pick its target. The encoding is 2'b00 for the mask, 2'b01 for the cursor index and 2'b10 for colour data.
- R3: Colour data bytes are taken in the order red, green, blue. An entry changes only on the blue byte, and it then holds red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R4: After each committed entry the cursor advances by one, and it wraps from the last entry (255 at defaults) to 0.
- R5: An index write moves the cursor to the written value and restarts the phase at red. Any red or green byte already received is dropped.
- R6: The pixel code is ANDed with the mask before lookup. A mask of 8'hFF passes every bit.
- R7: `pix_color` shows the entry selected by the pixel code presented one clock earlier.
- R8: When a blue byte commits an entry on the same edge that the pixel side reads that entry, the output carries the entry's old colour. The new colour appears from the next read.
- R9: A host write with `host_sel` = 2'b11 changes neither the mask, the cursor, the phase, nor any entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe, one byte per cycle |
| host_sel | input | 2 | Write target: mask, index, data or reserved |
| host_wdata | input | 8 | Host write byte |
| pix_idx | input | 8 | Pixel code, one per clock |
| pix_color | output | 24 | Looked-up colour, registered |

## Verification
The bench builds the block with its default widths: an 8-bit index and 8-bit colour channels. With these widths the 255-to-0 cursor wrap is reached with only one index write and three data bytes. The same widths let the pixel side exercise full, low-nibble and odd-bit masks against a small set of loaded entries. A blue commit is placed on the same edge as a read of its own entry, and an index write is placed in the middle of an entry's bytes, so that the ordering and restart rules are observed at the output.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int unsigned IDX_W = 8;
  localparam int unsigned CH_W  = 8;

  typedef enum logic [1:0] {
    SEL_MASK = 2'b00,
    SEL_IDX  = 2'b01,
    SEL_DATA = 2'b10,
    SEL_RSVD = 2'b11
  } host_sel_e;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  function automatic phase_e next_phase(input phase_e p);
    case (p)
      PH_RED:  return PH_GRN;
      PH_GRN:  return PH_BLU;
      default: return PH_RED;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] masked_code(input logic [IDX_W-1:0] code,
                                                  input logic [IDX_W-1:0] mask);
    return code & mask;
  endfunction

  function automatic logic [3*CH_W-1:0] pack_rgb(input logic [CH_W-1:0] r,
                                                input logic [CH_W-1:0] g,
                                                input logic [CH_W-1:0] b);
    return {r, g, b};
  endfunction
endpackage

// File: rtl/pal_host_seq.sv
module pal_host_seq
  import pal_pkg::*;
#(
  parameter int unsigned IW = IDX_W,
  parameter int unsigned CW = CH_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [CW-1:0] wdata,
  output logic [IW-1:0] mask_q,
  output logic [IW-1:0] cur_idx,
  output phase_e        phase,
  output logic          commit_fire,
  output logic [IW-1:0] commit_idx,
  output logic [3*CW-1:0] commit_data
);
  logic [CW-1:0] red_hold, grn_hold;
  logic data_wr, idx_wr, mask_wr;

  assign data_wr     = we && (sel == SEL_DATA);
  assign idx_wr      = we && (sel == SEL_IDX);
  assign mask_wr     = we && (sel == SEL_MASK);
  assign commit_fire = data_wr && (phase == PH_BLU);
  assign commit_idx  = cur_idx;
  assign commit_data = pack_rgb(red_hold, grn_hold, wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= '1;
      cur_idx  <= '0;
      phase    <= PH_RED;
      red_hold <= '0;
      grn_hold <= '0;
    end else begin
      if (mask_wr) mask_q <= wdata[IW-1:0];
      if (idx_wr) begin
        cur_idx <= wdata[IW-1:0];
        phase   <= PH_RED;
      end else if (data_wr) begin
        phase <= next_phase(phase);
        if (phase == PH_RED) red_hold <= wdata;
        if (phase == PH_GRN) grn_hold <= wdata;
        if (phase == PH_BLU) cur_idx  <= cur_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pal_store.sv
module pal_store
  import pal_pkg::*;
#(
  parameter int unsigned IW = IDX_W,
  parameter int unsigned DW = 3*CH_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << IW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en) mem[wr_idx] <= wr_data;
      rd_data <= mem[rd_idx];
    end
  end
endmodule

// File: rtl/pal_lut.sv
module pal_lut
  import pal_pkg::*;
#(
  parameter int unsigned IW = IDX_W,
  parameter int unsigned CW = CH_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [1:0]    host_sel,
  input  logic [CW-1:0] host_wdata,
  input  logic [IW-1:0] pix_idx,
  output logic [3*CW-1:0] pix_color
);
  localparam int unsigned DW = 3*CW;

  logic [IW-1:0] mask_q, cur_idx, commit_idx, lookup_idx;
  phase_e        phase;
  logic          commit_fire;
  logic [DW-1:0] commit_data;

  pal_host_seq #(.IW(IW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .we(host_we), .sel(host_sel), .wdata(host_wdata),
    .mask_q(mask_q), .cur_idx(cur_idx), .phase(phase),
    .commit_fire(commit_fire), .commit_idx(commit_idx), .commit_data(commit_data)
  );

  assign lookup_idx = masked_code(pix_idx, mask_q);

  pal_store #(.IW(IW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(commit_fire), .wr_idx(commit_idx),
    .wr_data(commit_data), .rd_idx(lookup_idx), .rd_data(pix_color)
  );
endmodule

// File: rtl/pal_lut_chk.sv
module pal_lut_chk
  import pal_pkg::*;
#(
  parameter int unsigned IW = IDX_W,
  parameter int unsigned CW = CH_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_we,
  input logic [1:0]    host_sel,
  input logic [CW-1:0] host_wdata,
  input logic [IW-1:0] mask_q,
  input logic [IW-1:0] cur_idx,
  input phase_e        phase,
  input logic          commit_fire
);
  p_commit_resets_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> phase == PH_RED);

  p_cursor_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> cur_idx == IW'($past(cur_idx) + 1'b1));

  p_index_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_sel == SEL_IDX) |=> (cur_idx == $past(host_wdata[IW-1:0])) && (phase == PH_RED));

  p_mask_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_sel == SEL_MASK) |=> mask_q == $past(host_wdata[IW-1:0]));

  p_reserved_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_sel == SEL_RSVD) |=> $stable(mask_q) && $stable(cur_idx) && $stable(phase));

  p_no_commit_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !host_we |-> !commit_fire);
endmodule

bind pal_lut pal_lut_chk #(.IW(IW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
  .host_wdata(host_wdata), .mask_q(mask_q), .cur_idx(cur_idx),
  .phase(phase), .commit_fire(commit_fire)
);

// File: tb/sim_pal_lut.sv
`timescale 1ns/1ps
module sim_pal_lut;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_we = 1'b0;
  logic [1:0] host_sel = 2'b00;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] pix_idx = 8'h00;
  logic [23:0] pix_color;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [23:0] model [256];
  logic [7:0]  m_mask = 8'hFF;
  logic [7:0]  m_cur = 8'h00;
  int          m_ph = 0;
  logic [7:0]  m_r, m_g;

  logic [23:0] exp_q [$];
  string       tag_q [$];

  always #2 clk = ~clk;

  pal_lut u0 (.clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
              .host_wdata(host_wdata), .pix_idx(pix_idx), .pix_color(pix_color));

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: results appear one clock after the code is driven
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [23:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, pix_color, e);
    end
  end

  // model update for one host write, applied at the same edge as the design
  function automatic void model_write(input logic [1:0] s, input logic [7:0] d);
    case (s)
      2'b00: m_mask = d;
      2'b01: begin m_cur = d; m_ph = 0; end
      2'b10: begin
        if (m_ph == 0) begin m_r = d; m_ph = 1; end
        else if (m_ph == 1) begin m_g = d; m_ph = 2; end
        else begin model[m_cur] = {m_r, m_g, d}; m_cur = m_cur + 8'd1; m_ph = 0; end
      end
      default: ;
    endcase
  endfunction

  // one cycle: optional host write plus a pixel lookup, expected from pre-edge model
  task automatic cycle(input bit we, input logic [1:0] s, input logic [7:0] d,
                       input logic [7:0] code, input string req);
    @(negedge clk);
    host_we = we; host_sel = s; host_wdata = d; pix_idx = code;
    exp_q.push_back(model[code & m_mask]);
    tag_q.push_back(req);
    if (we) model_write(s, d);
  endtask

  task automatic hwr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_sel = s; host_wdata = d;
    model_write(s, d);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic look(input logic [7:0] code, input string req);
    cycle(1'b0, 2'b00, 8'h00, code, req);
  endtask

  task automatic flush();
    @(negedge clk); host_we = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, colour zero, mask all ones
    @(negedge clk);
    check("R1 reset colour", pix_color, 24'h0);
    look(8'hFF, "R1 entry 255 zero");
    look(8'h00, "R1 entry 0 zero");
    flush();

    // R3: load entry 0 from reset cursor, R2 data select
    hwr(2'b10, 8'h11);
    look(8'h00, "R3 no commit after red");
    hwr(2'b10, 8'h22);
    look(8'h00, "R3 no commit after green");
    hwr(2'b10, 8'h33);
    look(8'h00, "R3 packed entry 0");
    look(8'h01, "R4 entry 1 still zero");
    flush();

    // R4: auto advance to entry 1
    hwr(2'b10, 8'hA1); hwr(2'b10, 8'hB2); hwr(2'b10, 8'hC3);
    look(8'h01, "R4 advanced to entry 1");
    flush();

    // R4: wrap from 255 to 0
    hwr(2'b01, 8'hFF);
    hwr(2'b10, 8'hDE); hwr(2'b10, 8'hAD); hwr(2'b10, 8'hBE);
    hwr(2'b10, 8'h01); hwr(2'b10, 8'h02); hwr(2'b10, 8'h03);
    look(8'hFF, "R4 entry 255 loaded");
    look(8'h00, "R4 wrap overwrote entry 0");
    flush();

    // R5: index write mid-entry drops partial bytes
    hwr(2'b01, 8'h40);
    hwr(2'b10, 8'h77); hwr(2'b10, 8'h88);
    hwr(2'b01, 8'h41);
    hwr(2'b10, 8'h10); hwr(2'b10, 8'h20); hwr(2'b10, 8'h30);
    look(8'h40, "R5 partial entry not written");
    look(8'h41, "R5 restart at red");
    flush();

    // R9: reserved select ignored (check mask, cursor, phase through outputs)
    hwr(2'b11, 8'h0F);
    look(8'hFF, "R9 mask untouched");
    hwr(2'b10, 8'h5A); hwr(2'b11, 8'h99); hwr(2'b10, 8'h6B); hwr(2'b10, 8'h7C);
    look(8'h42, "R9 phase and cursor untouched");
    flush();

    // R6: masks
    hwr(2'b00, 8'h0F);
    look(8'hF1, "R6 low-nibble mask");
    look(8'h42, "R6 masked to entry 2");
    hwr(2'b00, 8'h41);
    look(8'hFF, "R6 odd-bit mask to 0x41");
    look(8'hBE, "R6 odd-bit mask to 0x00");
    hwr(2'b00, 8'hFF);
    look(8'hFF, "R6 full mask");
    flush();

    // R7: back-to-back codes, each result one clock later
    look(8'h00, "R7 stream 0");
    look(8'h01, "R7 stream 1");
    look(8'hFF, "R7 stream 255");
    look(8'h41, "R7 stream 65");
    flush();

    // R8: commit and read of the same entry on one edge
    hwr(2'b01, 8'h01);
    hwr(2'b10, 8'hE0); hwr(2'b10, 8'hE1);
    cycle(1'b1, 2'b10, 8'hE2, 8'h01, "R8 same-edge read sees old");
    look(8'h01, "R8 next read sees new");
    flush();

    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule